// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block fetches a run of consecutive 16-bit words from a three-wire serial EEPROM that has a chip select, a shift clock, a command input and a data output. A host pulses a request with a start word address, a word count and a byte-swap choice. For every word the block selects the device, shifts out an 11-bit read command carrying that word's address, clocks in the 16 data bits, and releases the select again. Each finished word is presented for one cycle with a strobe and its position in the run.

The serial clock is paced from the system clock by a run-time divider value. One slot lasts `div + 1` system cycles. Each serial bit takes three slots: one with the clock low, during which the command bit is placed, and two with the clock high. Read data is sampled at the end of the high time, just before the clock falls. The request parameters are captured when the request is accepted, so the host can change its inputs while a run is in progress.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, `rom_cs`, `rom_sck`, `rom_di`, `busy`, `done` and `word_valid` are all 0.
- R2: For each word the block sends 11 command bits MSB first while `rom_cs` is high: the read code 0x180 ORed with the 6-bit word address, sampled by the EEPROM on each rising edge of `rom_sck`.
- R3: `rom_di` changes only while `rom_sck` is low. Each high phase of `rom_sck` lasts exactly 2*(div+1) cycles. Each low phase before a rising edge lasts at least div+1 cycles.
- R4: After the command, 16 bits are clocked in from `rom_do` MSB first, each taken while `rom_sck` is high. The assembled word appears on `word_data`.
- R5: Word i of a run is read from address (start_addr + i) mod 64. It is reported with `word_index` = i and a one-cycle `word_valid`, in increasing order of i.
- R6: When `swap` is 1 at the request, the high and low bytes of every reported word are exchanged. When it is 0, the word is reported unchanged.
- R7: `rom_cs` drops after every word and stays low for at least one full bit period (3*(div+1) cycles) before the next word. `rom_sck` is never high while `rom_cs` is low.
- R8: `done` pulses for one cycle after the last word of a run has been reported, and `busy` is 0 from that cycle on.
- R9: A request that arrives while `busy` is 1 is ignored. The running job keeps its own address, count and swap setting and reports no extra words.
- R10: A request with `word_count` = 0 produces a `done` pulse and no EEPROM access. `busy` and `rom_cs` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | 6 | Address of the first word |
| word_count | input | 7 | Number of words to read |
| swap | input | 1 | Byte-swap each word of this run |
| div | input | 8 | Slot length minus one, in system cycles |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_data | output | 16 | Word read, swapped if requested |
| word_index | output | 7 | Position of the word within the run |
| rom_cs | output | 1 | EEPROM chip select, active high |
| rom_sck | output | 1 | EEPROM serial clock |
| rom_di | output | 1 | Command bit to the EEPROM |
| rom_do | input | 1 | Data bit from the EEPROM |

## Verification
The bench uses the default parameters: 6-bit addresses, 16-bit words, a 7-bit count, an 8-bit divider, an 11-bit command, byte swapping compiled in and a three-slot gap. With these values, a run that starts near address 63 wraps back to address 0. The bench changes the divider between 0, 1, 2 and 3 from run to run. At divider 0 every slot is a single cycle, which tests the tightest phasing. The larger values test that the high and low phases and the inter-word gap scale with the slot length. An EEPROM model in the bench decodes each command from the pins, drives data derived from the address, and measures the phase and gap lengths.

// File: rtl/srr_pkg.sv
package srr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_CMD,
      ST_DATA,
      ST_GAP
   } srr_state_t;

   typedef enum logic [1:0] {
      PH_LOW,
      PH_HIGH_A,
      PH_HIGH_B
   } srr_phase_t;

endpackage

// File: rtl/srr_tick_gen.sv
module srr_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = en && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/srr_cmd_shifter.sv
module srr_cmd_shifter #(
   parameter int CMD_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] load_val,
   input  logic             shift,
   output logic             msb
);

   logic [CMD_W-1:0] sh_q;

   assign msb = sh_q[CMD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_val;
      end else if (shift) begin
         sh_q <= {sh_q[CMD_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/srr_word_capture.sv
module srr_word_capture #(
   parameter int DATA_W  = 16,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift,
   input  logic              bit_in,
   input  logic              swap,
   output logic [DATA_W-1:0] word
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (clear) begin
         sh_q <= '0;
      end else if (shift) begin
         sh_q <= {sh_q[DATA_W-2:0], bit_in};
      end
   end

   generate
      if (SWAP_EN) begin : g_swap
         if ((DATA_W % 2) != 0) begin : g_bad_width
            $error("srr_word_capture: swapping needs an even DATA_W");
         end
         assign word = swap ? {sh_q[HALF_W-1:0], sh_q[DATA_W-1:HALF_W]} : sh_q;
      end else begin : g_plain
         logic unused_swap;
         assign unused_swap = swap;
         assign word = sh_q;
      end
   endgenerate

endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
   import srr_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 7,
   parameter int DIV_W     = 8,
   parameter int CMD_W     = 11,
   parameter bit SWAP_EN   = 1'b1,
   parameter int GAP_SLOTS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              swap,
   input  logic [DIV_W-1:0]  div,
   output logic              busy,
   output logic              done,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data,
   output logic [CNT_W-1:0]  word_index,
   output logic              rom_cs,
   output logic              rom_sck,
   output logic              rom_di,
   input  logic              rom_do
);

   localparam int MAX_BITS = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int BIT_W    = $clog2(MAX_BITS);
   localparam int GAP_W    = $clog2(GAP_SLOTS + 1);
   localparam logic [CMD_W-1:0] READ_CODE = CMD_W'(3'b110) << ADDR_W;

   generate
      if (CMD_W < ADDR_W + 3) begin : g_bad_cmd
         $error("serial_rom_reader: CMD_W too small for start bit, opcode and address");
      end
      if (GAP_SLOTS < 3) begin : g_bad_gap
         $error("serial_rom_reader: gap must cover one full bit period");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("serial_rom_reader: DATA_W must be at least 2");
      end
   endgenerate

   srr_state_t        state_q;
   srr_phase_t        phase_q;
   logic [BIT_W-1:0]  bit_q;
   logic [GAP_W-1:0]  gap_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  idx_q;
   logic              swap_q;
   logic              cs_q;
   logic              sck_q;
   logic              done_q;
   logic              emit_q;

   logic              tick;
   logic              cmd_msb;
   logic [ADDR_W-1:0] cur_addr;
   logic [CMD_W-1:0]  cmd_word;
   logic              cmd_load;
   logic              cmd_shift;
   logic              data_shift;
   logic              bit_end;

   assign cur_addr   = addr_q + ADDR_W'(idx_q);
   assign cmd_word   = READ_CODE | CMD_W'(cur_addr);
   assign bit_end    = tick && (phase_q == PH_HIGH_B);
   assign cmd_load   = (state_q == ST_SEL) && tick;
   assign cmd_shift  = (state_q == ST_CMD) && bit_end;
   assign data_shift = (state_q == ST_DATA) && bit_end;

   srr_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state_q != ST_IDLE),
      .div   (div),
      .tick  (tick)
   );

   srr_cmd_shifter #(.CMD_W(CMD_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cmd_load),
      .load_val (cmd_word),
      .shift    (cmd_shift),
      .msb      (cmd_msb)
   );

   srr_word_capture #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cmd_load),
      .shift  (data_shift),
      .bit_in (rom_do),
      .swap   (swap_q),
      .word   (word_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_LOW;
         bit_q   <= '0;
         gap_q   <= '0;
         addr_q  <= '0;
         count_q <= '0;
         idx_q   <= '0;
         swap_q  <= 1'b0;
         cs_q    <= 1'b0;
         sck_q   <= 1'b0;
         done_q  <= 1'b0;
         emit_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         emit_q <= 1'b0;
         if (emit_q) begin
            idx_q <= idx_q + 1'b1;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (req) begin
                  addr_q  <= start_addr;
                  count_q <= word_count;
                  swap_q  <= swap;
                  idx_q   <= '0;
                  if (word_count == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= ST_SEL;
                     cs_q    <= 1'b1;
                  end
               end
            end
            ST_SEL: begin
               if (tick) begin
                  state_q <= ST_CMD;
                  phase_q <= PH_LOW;
                  bit_q   <= BIT_W'(CMD_W - 1);
               end
            end
            ST_CMD, ST_DATA: begin
               if (tick) begin
                  unique case (phase_q)
                     PH_LOW: begin
                        sck_q   <= 1'b1;
                        phase_q <= PH_HIGH_A;
                     end
                     PH_HIGH_A: begin
                        phase_q <= PH_HIGH_B;
                     end
                     default: begin
                        sck_q   <= 1'b0;
                        phase_q <= PH_LOW;
                        if (bit_q != '0) begin
                           bit_q <= bit_q - 1'b1;
                        end else if (state_q == ST_CMD) begin
                           state_q <= ST_DATA;
                           bit_q   <= BIT_W'(DATA_W - 1);
                        end else begin
                           state_q <= ST_GAP;
                           cs_q    <= 1'b0;
                           emit_q  <= 1'b1;
                           gap_q   <= '0;
                        end
                     end
                  endcase
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_q == GAP_W'(GAP_SLOTS - 1)) begin
                     if (idx_q == count_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ST_SEL;
                        cs_q    <= 1'b1;
                     end
                  end else begin
                     gap_q <= gap_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
               cs_q    <= 1'b0;
               sck_q   <= 1'b0;
            end
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign word_valid = emit_q;
   assign word_index = idx_q;
   assign rom_cs     = cs_q;
   assign rom_sck    = sck_q;
   assign rom_di     = (state_q == ST_CMD) && cmd_msb;

endmodule

// File: rtl/serial_rom_reader_checker.sv
module serial_rom_reader_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic word_valid,
   input logic rom_cs,
   input logic rom_sck,
   input logic rom_di
);

   // R3: command bit is settled before the clock rises
   a_r3_di_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_sck) |-> $stable(rom_di));

   // R3: command bit does not move while the clock is high
   a_r3_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_sck && $past(rom_sck)) |-> $stable(rom_di));

   // R7: no clocking while deselected
   a_r7_no_clock_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs |-> !rom_sck);

   // R7: select is only driven inside a run
   a_r7_cs_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs |-> busy);

   // R5: one-cycle word strobe, issued inside a run with the device released
   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   a_r5_valid_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (busy && !rom_cs));

   // R8: done is a single pulse seen with the block idle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind serial_rom_reader serial_rom_reader_checker u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .word_valid (word_valid),
   .rom_cs     (rom_cs),
   .rom_sck    (rom_sck),
   .rom_di     (rom_di)
);

// File: tb/serial_rom_reader_test.sv
module serial_rom_reader_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [5:0]  start_addr = '0;
   logic [6:0]  word_count = '0;
   logic        swap = 1'b0;
   logic [7:0]  div = '0;
   logic        busy, done, word_valid;
   logic [15:0] word_data;
   logic [6:0]  word_index;
   logic        rom_cs, rom_sck, rom_di;
   logic        rom_do = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   serial_rom_reader uut (
      .clk(clk), .rst_n(rst_n), .req(req), .start_addr(start_addr),
      .word_count(word_count), .swap(swap), .div(div), .busy(busy),
      .done(done), .word_valid(word_valid), .word_data(word_data),
      .word_index(word_index), .rom_cs(rom_cs), .rom_sck(rom_sck),
      .rom_di(rom_di), .rom_do(rom_do)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] mem_word(input logic [5:0] a);
      return {2'b10, a, a ^ 6'h15, 2'b11};
   endfunction

   // monitor / EEPROM model state
   logic [15:0] wdat [0:31];
   logic [6:0]  widx [0:31];
   logic [10:0] clog [0:31];
   int wn, cn, done_n, done_cyc, last_valid_cyc, ph_err, gap_err, gap_run;
   int hi_run, lo_run, edges;
   bit busy_seen;
   logic cs_prev = 1'b0, sck_prev = 1'b0, di_prev = 1'b0;
   logic [10:0] cmd_sh;
   logic [5:0]  cur_a;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish act=%0d exp<%0d", cyc, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_seen = 1'b1;
         if (word_valid && wn < 32) begin
            wdat[wn] = word_data;
            widx[wn] = word_index;
            wn++;
            last_valid_cyc = cyc;
         end
         if (done) begin
            done_n++;
            done_cyc = cyc;
         end
         if (!rom_cs) begin
            if (rom_sck) ph_err++;
            gap_run++;
            edges  = 0;
            rom_do = 1'b0;
         end else begin
            if (!cs_prev) begin
               if (gap_run < 3 * (int'(div) + 1)) gap_err++;
               gap_run = 0;
               hi_run  = 0;
               lo_run  = 0;
               cmd_sh  = '0;
            end
            if (rom_sck && !sck_prev) begin
               if (rom_di !== di_prev) ph_err++;
               if (lo_run < int'(div) + 1) ph_err++;
               edges++;
               hi_run = 1;
               if (edges <= 11) begin
                  cmd_sh = {cmd_sh[9:0], rom_di};
                  if (edges == 11 && cn < 32) begin
                     clog[cn] = cmd_sh;
                     cn++;
                     cur_a = cmd_sh[5:0];
                  end
               end else if (edges <= 27) begin
                  rom_do = mem_word(cur_a)[15 - (edges - 12)];
               end
            end else if (rom_sck) begin
               hi_run++;
               if (rom_di !== di_prev) ph_err++;
            end
            if (!rom_sck && sck_prev) begin
               if (hi_run != 2 * (int'(div) + 1)) ph_err++;
               lo_run = 1;
            end else if (!rom_sck) begin
               lo_run++;
            end
         end
         cs_prev  = rom_cs;
         sck_prev = rom_sck;
         di_prev  = rom_di;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_logs();
      wn = 0; cn = 0; done_n = 0; done_cyc = 0; last_valid_cyc = 0;
      ph_err = 0; gap_err = 0; gap_run = 1000; busy_seen = 1'b0;
   endtask

   task automatic launch(input logic [5:0] a, input logic [6:0] n,
                         input logic sw, input logic [7:0] dv);
      @(negedge clk);
      div = dv; start_addr = a; word_count = n; swap = sw; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done();
      while (done_n == 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic verify(input string tag, input logic [5:0] a, input int n, input logic sw);
      chk({tag, " R5 word count"}, wn, n);
      chk({tag, " R2 command count"}, cn, n);
      for (int i = 0; i < n; i++) begin
         logic [5:0]  ea;
         logic [15:0] ew;
         ea = a + 6'(i);
         ew = mem_word(ea);
         if (sw) ew = {ew[7:0], ew[15:8]};
         chk($sformatf("%s R2 command word %0d", tag, i), clog[i], 11'h180 | 11'(ea));
         chk($sformatf("%s R5 index %0d", tag, i), widx[i], i);
         chk($sformatf("%s R4/R6 data %0d", tag, i), wdat[i], ew);
      end
      chk({tag, " R3 phase errors"}, ph_err, 0);
      chk({tag, " R7 gap errors"}, gap_err, 0);
      chk({tag, " R8 single done"}, done_n, 1);
      chk({tag, " R8 done after last word"}, done_cyc > last_valid_cyc, 1);
      chk({tag, " R8 idle after done"}, {busy, rom_cs}, 0);
   endtask

   task automatic test_reset();
      chk("R1 rom_cs", rom_cs, 0);
      chk("R1 rom_sck", rom_sck, 0);
      chk("R1 rom_di", rom_di, 0);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 word_valid", word_valid, 0);
   endtask

   task automatic test_single();
      clear_logs();
      launch(6'h05, 7'd1, 1'b0, 8'd0);
      wait_done();
      verify("single", 6'h05, 1, 1'b0);
   endtask

   task automatic test_multi();
      clear_logs();
      launch(6'h10, 7'd4, 1'b0, 8'd2);
      wait_done();
      verify("multi", 6'h10, 4, 1'b0);
   endtask

   task automatic test_swap();
      clear_logs();
      launch(6'h21, 7'd3, 1'b1, 8'd1);
      wait_done();
      verify("swap R6", 6'h21, 3, 1'b1);
   endtask

   task automatic test_wrap();
      clear_logs();
      launch(6'h3E, 7'd4, 1'b0, 8'd0);
      wait_done();
      verify("wrap R5", 6'h3E, 4, 1'b0);
   endtask

   task automatic test_slow();
      clear_logs();
      launch(6'h07, 7'd2, 1'b1, 8'd3);
      wait_done();
      verify("slow R3", 6'h07, 2, 1'b1);
   endtask

   task automatic test_zero();
      clear_logs();
      launch(6'h09, 7'd0, 1'b0, 8'd0);
      repeat (20) @(negedge clk);
      chk("R10 done pulse", done_n, 1);
      chk("R10 no words", wn, 0);
      chk("R10 no commands", cn, 0);
      chk("R10 never busy", busy_seen, 0);
   endtask

   task automatic test_busy_ignore();
      clear_logs();
      launch(6'h02, 7'd2, 1'b0, 8'd0);
      repeat (30) @(negedge clk);
      chk("R9 busy during run", busy, 1);
      start_addr = 6'h28; word_count = 7'd5; swap = 1'b1; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      wait_done();
      verify("busy R9", 6'h02, 2, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      test_single();
      test_multi();
      test_swap();
      test_wrap();
      test_slow();
      test_zero();
      test_busy_ignore();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule